// File: doc/BRIEF.md
# Linked-List Command Unit with Suspend Handoff

This block walks a chain of command blocks kept in system memory. Each block is two 32-bit words. The head word carries a 16-bit command in bits 31:16 and a 16-bit status in bits 15:0. The word at the next address (head + 4) is the 32-bit address of the following block. For every block, the unit reads both words and carries out the command, modelled as an action of fixed length. It then writes the head word back with completion flags set and moves along the link.

The host drives the unit through a small command register. The register holds a 2-bit command code and a general pointer. Start loads the pointer as the address of the first block. Resume continues after a pause. The register clears itself once the unit takes the command.

A block can ask the unit to pause after it by setting a suspend flag in its command. To add work, the host does three things in order. It sets suspend on the new tail block. It clears suspend on the old tail. It then issues resume. The unit re-reads the link of the last block it completed, so it picks up a link the host rewrote while the unit was paused. To cut the number of interrupts, the unit raises one only on every Nth completed block.

The control state machine has seven states. IDLE and SUSPENDED are the resting states; they accept start (to READ_HEAD), and SUSPENDED also accepts resume (to RELINK). READ_HEAD goes to READ_LINK when memory acknowledges. READ_LINK goes to EXECUTE when memory acknowledges. EXECUTE goes to WRITE_STATUS when the action timer expires. WRITE_STATUS, once acknowledged, goes to IDLE if end-of-list is set. Otherwise it goes to SUSPENDED if suspend is set, and to READ_HEAD on the link if neither is set. RELINK reads the last block's link and goes to READ_HEAD.

Top module: `cu_listwalk`

## Requirements
- R1: After reset, `unit_state` is 0, `cmd_pending`, `irq` and `mem_req` are all low.
- R2: A start command (code 1) seen while the unit is idle or suspended is taken on the next clock edge. `cmd_pending` drops, and the first block is read at the address given in `host_ptr`.
- R3: For each block at address A, the unit reads the head word at A and the link at A+4. It waits EXEC_CYCLES cycles, then writes the head word back to A. The write-back keeps the command half and the other status bits, and sets status bit 15 (complete) and bit 13 (ok). A memory request holds its address and direction until `mem_ack`.
- R4: When a completed block has neither command bit 15 nor bit 14 set (word bits 31 and 30), the unit goes on to the block at its link address.
- R5: When a completed block has command bit 14 (suspend) set, the unit enters the suspended state (code 2) after its write-back and makes no further memory access.
- R6: When a completed block has command bit 15 (end of list) set, the unit enters idle (code 0) after its write-back. End of list wins over suspend.
- R7: A resume command (code 2) in the suspended state makes the unit re-read the link word at last-completed-block + 4 and continue from that address.
- R8: A resume command seen while the unit is idle or active has no effect on the walk. `cmd_pending` still drops on the next clock edge.
- R9: A start command seen while the unit is active keeps `cmd_pending` high and is taken once the unit becomes idle or suspended.
- R10: `irq` is a one-cycle pulse raised on every IRQ_EVERY-th completed block, counted across all runs since reset (default 16).
- R11: `unit_state` is 0 idle, 1 active or 2 suspended, never 3. `mem_req` is high only while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd_we | input | 1 | Host write strobe for the command register |
| host_cmd | input | 2 | Command code: 0 none, 1 start, 2 resume |
| host_ptr | input | ADDR_W | General pointer written with the command |
| cmd_pending | output | 1 | Command register holds a command not yet taken |
| unit_state | output | 2 | 0 idle, 1 active, 2 suspended |
| irq | output | 1 | Interrupt pulse every IRQ_EVERY completed blocks |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the access |

## Verification
The hardest cases to reach are the races between a host command and a walk that is still in progress. One is a resume that arrives while blocks are still executing. The other is a start that must wait until the unit pauses. The bench issues these commands a few cycles after a start, while the unit is still in its first block. It then shows through the memory image that the resume did not carry the walk past the next suspend point, and that the queued start began its own chain right after the pause. The link re-read on resume is reached by rewriting the paused block's link in memory before resuming. The bench then checks that the old successor stays untouched.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUSP,
        ST_RD_HEAD,
        ST_RD_LINK,
        ST_EXEC,
        ST_WR_STAT,
        ST_RELINK
    } cu_state_e;

    typedef enum logic [1:0] {
        HC_NONE   = 2'd0,
        HC_START  = 2'd1,
        HC_RESUME = 2'd2,
        HC_RSVD   = 2'd3
    } host_cmd_e;

    // head word layout: command in 31:16, status in 15:0
    localparam int BIT_END  = 31;
    localparam int BIT_SUSP = 30;
    localparam int BIT_DONE = 15;
    localparam int BIT_OK   = 13;

    localparam logic [1:0] US_IDLE   = 2'd0;
    localparam logic [1:0] US_ACTIVE = 2'd1;
    localparam logic [1:0] US_SUSP   = 2'd2;

endpackage

// File: rtl/cu_host_cmd_reg.sv
module cu_host_cmd_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_code,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic              take,
    output logic [1:0]        code_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              pending
);
    import cu_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= HC_NONE;
            ptr_q  <= '0;
        end else if (wr_en) begin
            code_q <= wr_code;
            ptr_q  <= wr_ptr;
        end else if (take) begin
            code_q <= HC_NONE;
        end
    end

    assign pending = (code_q != HC_NONE);

endmodule

// File: rtl/cu_exec_timer.sv
module cu_exec_timer #(
    parameter int EXEC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(EXEC_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (kick) begin
            cnt_q <= CW'(EXEC_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/cu_irq_div.sv
module cu_irq_div #(
    parameter int IRQ_EVERY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_done,
    output logic irq
);
    localparam int CW = (IRQ_EVERY > 1) ? $clog2(IRQ_EVERY) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else if (blk_done) begin
            if (cnt_q == CW'(IRQ_EVERY - 1)) begin
                cnt_q <= '0;
                irq   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                irq   <= 1'b0;
            end
        end else begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/cu_listwalk.sv
module cu_listwalk #(
    parameter int ADDR_W      = 32,
    parameter int EXEC_CYCLES = 4,
    parameter int IRQ_EVERY   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cmd_we,
    input  logic [1:0]        host_cmd,
    input  logic [ADDR_W-1:0] host_ptr,
    output logic              cmd_pending,
    output logic [1:0]        unit_state,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    import cu_pkg::*;

    localparam int DATA_W     = 32;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] DONE_MASK =
        (DATA_W'(1) << BIT_DONE) | (DATA_W'(1) << BIT_OK);

    cu_state_e         state_q, state_d;
    logic [1:0]        hc_code;
    logic [ADDR_W-1:0] hc_ptr;
    logic              hc_take;
    logic              take_start, take_resume, at_rest;
    logic              exec_kick, exec_expired, blk_done;
    logic [ADDR_W-1:0] cur_addr_q, last_addr_q;
    logic [DATA_W-1:0] head_q, link_q;

    cu_host_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_cmd_we),
        .wr_code (host_cmd),
        .wr_ptr  (host_ptr),
        .take    (hc_take),
        .code_q  (hc_code),
        .ptr_q   (hc_ptr),
        .pending (cmd_pending)
    );

    cu_exec_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (exec_kick),
        .expired (exec_expired)
    );

    cu_irq_div #(.IRQ_EVERY(IRQ_EVERY)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_done (blk_done),
        .irq      (irq)
    );

    // host command acceptance
    assign at_rest     = (state_q == ST_IDLE) || (state_q == ST_SUSP);
    assign take_start  = cmd_pending && (hc_code == HC_START) && at_rest;
    assign take_resume = cmd_pending && (hc_code == HC_RESUME) && (state_q == ST_SUSP);
    // anything but a start is consumed at once; a start waits for rest
    assign hc_take     = cmd_pending && ((hc_code != HC_START) || at_rest);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_start) state_d = ST_RD_HEAD;
            end
            ST_SUSP: begin
                if (take_start)       state_d = ST_RD_HEAD;
                else if (take_resume) state_d = ST_RELINK;
            end
            ST_RD_HEAD: begin
                if (mem_ack) state_d = ST_RD_LINK;
            end
            ST_RD_LINK: begin
                if (mem_ack) state_d = ST_EXEC;
            end
            ST_EXEC: begin
                if (exec_expired) state_d = ST_WR_STAT;
            end
            ST_WR_STAT: begin
                if (mem_ack) begin
                    if (head_q[BIT_END])       state_d = ST_IDLE;
                    else if (head_q[BIT_SUSP]) state_d = ST_SUSP;
                    else                       state_d = ST_RD_HEAD;
                end
            end
            ST_RELINK: begin
                if (mem_ack) state_d = ST_RD_HEAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr_q;
        mem_wdata  = head_q | DONE_MASK;
        exec_kick  = 1'b0;
        blk_done   = 1'b0;
        unit_state = US_ACTIVE;
        unique case (state_q)
            ST_IDLE:    unit_state = US_IDLE;
            ST_SUSP:    unit_state = US_SUSP;
            ST_RD_HEAD: mem_req = 1'b1;
            ST_RD_LINK: begin
                mem_req   = 1'b1;
                mem_addr  = cur_addr_q + LINK_OFS;
                exec_kick = mem_ack;
            end
            ST_EXEC:    ;
            ST_WR_STAT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                blk_done = mem_ack;
            end
            ST_RELINK: begin
                mem_req  = 1'b1;
                mem_addr = last_addr_q + LINK_OFS;
            end
            default: unit_state = US_IDLE;
        endcase
    end

    // block datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            last_addr_q <= '0;
            head_q      <= '0;
            link_q      <= '0;
        end else begin
            if (take_start) begin
                cur_addr_q <= hc_ptr;
            end
            if (state_q == ST_RD_HEAD && mem_ack) begin
                head_q <= mem_rdata;
            end
            if (state_q == ST_RD_LINK && mem_ack) begin
                link_q <= mem_rdata;
            end
            if (blk_done) begin
                last_addr_q <= cur_addr_q;
                cur_addr_q  <= link_q[ADDR_W-1:0];
            end
            if (state_q == ST_RELINK && mem_ack) begin
                cur_addr_q <= mem_rdata[ADDR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cu_listwalk_chk.sv
module cu_listwalk_chk #(
    parameter int ADDR_W    = 32,
    parameter int IRQ_EVERY = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        unit_state,
    input logic              cmd_pending,
    input logic [1:0]        cmd_code,
    input logic              host_cmd_we,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata
);
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state != 2'd3); // R11

    AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_state != 2'd1) |-> !mem_req); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

    AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[15] && mem_wdata[13])); // R3

    AST_RESUME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && cmd_code == 2'd2 && unit_state == 2'd1 && !host_cmd_we)
        |=> !cmd_pending); // R8

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && cmd_code == 2'd1 && unit_state == 2'd1 && !host_cmd_we)
        |=> cmd_pending); // R9

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && IRQ_EVERY > 1) |=> !irq); // R10

endmodule

bind cu_listwalk cu_listwalk_chk #(.ADDR_W(ADDR_W), .IRQ_EVERY(IRQ_EVERY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_state  (unit_state),
    .cmd_pending (cmd_pending),
    .cmd_code    (hc_code),
    .host_cmd_we (host_cmd_we),
    .irq         (irq),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
);

// File: tb/cu_listwalk_tb_top.sv
module cu_listwalk_tb_top;

    localparam int ADDR_W    = 32;
    localparam int EXEC_CYC  = 4;
    localparam int IRQ_N     = 16;
    localparam int NBLK      = 20;

    // per entry: {expected rest state[1:0], end flag, suspend flag}
    localparam logic [3:0] TBL [0:NBLK-1] = '{
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1001,
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1001,
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010,
        4'b0000, 4'b0000, 4'b1001, 4'b0000, 4'b0011
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_cmd_we = 1'b0;
    logic [1:0]        host_cmd = 2'd0;
    logic [ADDR_W-1:0] host_ptr = '0;
    logic              cmd_pending, irq, mem_req, mem_we;
    logic [1:0]        unit_state;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_ack = 1'b0;

    logic [31:0] mem [0:255];
    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;

    always #5 clk = ~clk;

    cu_listwalk #(.ADDR_W(ADDR_W), .EXEC_CYCLES(EXEC_CYC), .IRQ_EVERY(IRQ_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_cmd_we(host_cmd_we), .host_cmd(host_cmd),
        .host_ptr(host_ptr), .cmd_pending(cmd_pending), .unit_state(unit_state),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && irq) irq_seen <= irq_seen + 1;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tbl_addr(input int i);
        return 32'h100 + 32'(i) * 16;
    endfunction
    function automatic logic [15:0] tbl_cmd(input int i);
        return {TBL[i][1:0], 6'd0, 8'(i)};
    endfunction
    function automatic logic [15:0] tbl_stat(input int i);
        return 16'h0100 | 16'(i);
    endfunction

    task automatic put_blk(input logic [31:0] a, input logic [15:0] c,
                           input logic [15:0] s, input logic [31:0] lnk);
        mem[a[9:2]]     = {c, s};
        mem[a[9:2] + 1] = lnk;
    endtask

    task automatic chk_done(input string tag, input logic [31:0] a,
                            input logic [15:0] c, input logic [15:0] s);
        check_eq(tag, mem[a[9:2]], {c, s | 16'hA000});
    endtask

    task automatic chk_fresh(input string tag, input logic [31:0] a,
                             input logic [15:0] c, input logic [15:0] s);
        check_eq(tag, mem[a[9:2]], {c, s});
    endtask

    task automatic issue(input logic [1:0] code, input logic [31:0] p);
        @(negedge clk);
        host_cmd_we = 1'b1;
        host_cmd    = code;
        host_ptr    = p;
        @(negedge clk);
        host_cmd_we = 1'b0;
        host_cmd    = 2'd0;
    endtask

    task automatic settle();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (unit_state != 2'd1 && !cmd_pending) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int seg;
        int total;
        logic [1:0] last_stop;
        for (int k = 0; k < 256; k++) mem[k] = '0;
        for (int i = 0; i < NBLK; i++)
            put_blk(tbl_addr(i), tbl_cmd(i), tbl_stat(i), tbl_addr(i + 1));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 unit_state", 32'(unit_state), 32'd0);
        check_eq("R1 cmd_pending", 32'(cmd_pending), 32'd0);
        check_eq("R1 mem_req", 32'(mem_req), 32'd0);
        check_eq("R1 irq", 32'(irq), 32'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R10
        seg = 0; total = 0; last_stop = 2'd0;
        for (int i = 0; i < NBLK; i++) begin
            if (TBL[i][1:0] == 2'b00) continue;
            if (last_stop == 2'd0) issue(2'd1, tbl_addr(seg));
            else                   issue(2'd2, 32'd0);
            settle();
            check_eq("R5_R6 rest state", 32'(unit_state), 32'(TBL[i][3:2]));
            for (int j = seg; j <= i; j++)
                chk_done("R3_R4_R7 block written back", tbl_addr(j), tbl_cmd(j), tbl_stat(j));
            if (i + 1 < NBLK)
                chk_fresh("R5_R6 next block untouched", tbl_addr(i + 1), tbl_cmd(i + 1), tbl_stat(i + 1));
            total += i - seg + 1;
            check_eq("R10 irq pulses", 32'(irq_seen), 32'(total / IRQ_N));
            last_stop = unit_state;
            seg = i + 1;
        end

        // R8: resume while idle is dropped
        issue(2'd2, 32'd0);
        @(negedge clk);
        check_eq("R8 idle resume cleared", 32'(cmd_pending), 32'd0);
        check_eq("R8 idle resume state", 32'(unit_state), 32'd0);

        // R7: link rewritten during suspend is followed
        put_blk(32'h300, 16'h4001, 16'h0011, 32'h310);
        put_blk(32'h310, 16'h8002, 16'h0022, 32'h0);
        put_blk(32'h320, 16'h8003, 16'h0033, 32'h0);
        issue(2'd1, 32'h300);
        settle();
        check_eq("R5 suspended at first", 32'(unit_state), 32'd2);
        mem[8'hC1] = 32'h320;
        issue(2'd2, 32'd0);
        settle();
        check_eq("R7 idle after relink", 32'(unit_state), 32'd0);
        chk_done("R7 new successor done", 32'h320, 16'h8003, 16'h0033);
        chk_fresh("R7 old successor untouched", 32'h310, 16'h8002, 16'h0022);
        total += 2;

        // R8: resume while active is dropped, walk stops at suspend
        put_blk(32'h340, 16'h0004, 16'h0000, 32'h350);
        put_blk(32'h350, 16'h4005, 16'h0000, 32'h360);
        put_blk(32'h360, 16'h8006, 16'h0000, 32'h0);
        issue(2'd1, 32'h340);
        @(negedge clk);
        issue(2'd2, 32'd0);
        @(negedge clk);
        check_eq("R8 active resume cleared", 32'(cmd_pending), 32'd0);
        check_eq("R8 still active", 32'(unit_state), 32'd1);
        settle();
        check_eq("R8 rests suspended", 32'(unit_state), 32'd2);
        chk_done("R8 suspend block done", 32'h350, 16'h4005, 16'h0000);
        chk_fresh("R8 resume had no effect", 32'h360, 16'h8006, 16'h0000);
        total += 2;

        // R9: start while active is held, then taken at suspend (R2)
        put_blk(32'h380, 16'h0007, 16'h0000, 32'h390);
        put_blk(32'h390, 16'h4008, 16'h0000, 32'h3A0);
        put_blk(32'h3C0, 16'h8009, 16'h0000, 32'h0);
        issue(2'd1, 32'h380);
        @(negedge clk);
        issue(2'd1, 32'h3C0);
        @(negedge clk);
        check_eq("R9 start held pending", 32'(cmd_pending), 32'd1);
        check_eq("R9 still active", 32'(unit_state), 32'd1);
        settle();
        check_eq("R9 idle at end", 32'(unit_state), 32'd0);
        chk_done("R9 first chain done", 32'h390, 16'h4008, 16'h0000);
        chk_done("R2 queued start block done", 32'h3C0, 16'h8009, 16'h0000);
        total += 3;
        check_eq("R10 total irq pulses", 32'(irq_seen), 32'(total / IRQ_N));

        report();
        $finish;
    end

endmodule